// File: doc/BRIEF.md
# Watchdog Timer with Clear Sequencing and Status Flags

This block is the watchdog of a small microcontroller core. A counter advances on enable pulses taken from one of two time bases: a dedicated low-power oscillator that keeps running while the core sleeps, or the instruction clock, which stops during power-down. If software fails to restart the counter before it reaches a programmable terminal count, the block raises a one-cycle reset request. The kind of request depends on the sleep state. Awake, it asks for a full device reset. Asleep, it asks for a warm reset, in which only the program counter and stack pointer return to zero.

Software restarts the counter in one of two ways, and a static option picks the way. In single mode, one clear strobe is enough. In dual mode, two separate clear strobes (half A and half B) must both arrive, in either order. Each half is remembered until the pair is complete. The block also keeps two status bits that software reads after a restart to learn its cause: a time-out flag and a power-down flag. A HALT strobe from the core clears the counter, sets the power-down flag and clears the time-out flag.

All inputs are sampled on `clk`. The tick inputs are one-cycle enables, already brought into this clock domain. `rst_n` is the synchronous, active-low power-up and external reset.

Top module: `wdt_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter and both half records are cleared. After that edge, `to_flag`, `pd_flag`, `full_rst_req` and `warm_rst_req` all read 0.
- R2: With `wd_en`=1, each selected tick advances the counter by one. The TERM_COUNT-th tick since the last clear is an overflow. An overflow restarts the counter from zero, and its request output is high for exactly one cycle, the cycle after the edge that took the tick.
- R3: An overflow while `pwr_down`=0 pulses `full_rst_req` and sets `to_flag`. `warm_rst_req` stays 0.
- R4: An overflow while `pwr_down`=1 pulses `warm_rst_req` and sets `to_flag`. `full_rst_req` stays 0.
- R5: In single mode (`dual_clr_mode`=0), `kick` clears the counter and clears `pd_flag`. `kick_a` and `kick_b` have no effect on the counter or on the flags.
- R6: In dual mode (`dual_clr_mode`=1), `kick` has no effect. The counter clears, and `pd_flag` clears, on the edge where both halves have been received, either earlier or on that edge, in any order or together. The half records are emptied by that clear, by HALT, by an overflow, and by leaving dual mode.
- R7: `halt_exec` clears the counter and the half records, sets `pd_flag` and clears `to_flag`. In the same cycle it takes priority over a software clear and over an overflow, and no request is raised.
- R8: With `lp_clk_sel`=1, the counter takes `lp_tick`. With `lp_clk_sel`=0, it takes `ins_tick`, and ignores it while `pwr_down`=1.
- R9: With `wd_en`=0, the counter holds its value and no overflow occurs. Clears and HALT still act.
- R10: A software clear in the same cycle as the terminal tick wins: the counter restarts, no request is raised and `to_flag` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-up / external reset |
| wd_en | input | 1 | Watchdog enable option |
| dual_clr_mode | input | 1 | 1 = two-strobe clear, 0 = single-strobe clear |
| lp_clk_sel | input | 1 | 1 = low-power oscillator time base, 0 = instruction clock |
| lp_tick | input | 1 | One-cycle pulse from the low-power oscillator |
| ins_tick | input | 1 | One-cycle pulse from the instruction clock |
| pwr_down | input | 1 | Core is in power-down |
| kick | input | 1 | Single-mode clear strobe |
| kick_a | input | 1 | Dual-mode clear strobe, half A |
| kick_b | input | 1 | Dual-mode clear strobe, half B |
| halt_exec | input | 1 | HALT instruction strobe |
| full_rst_req | output | 1 | One-cycle full device reset request |
| warm_rst_req | output | 1 | One-cycle warm reset request |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |

## Verification
The hardest situation to reach is a clear event that lands on the very cycle of the terminal tick. Examples are a completing dual-mode half, a single kick or a HALT arriving exactly when the counter would overflow. The counter is not visible at the ports, so directed cases use the bench's own model count to drive ticks until the model sits one tick short of the terminal count. They then fire the tick together with the clear or HALT. Random stimulus with a fixed seed then mixes modes, clock sources, sleep and sparse clears over thousands of cycles, and a small terminal count keeps overflows frequent.

// File: rtl/wdt_guard_pkg.sv
// Package: shared types for the watchdog block.
// Assumes: all strobes are single-cycle and synchronous to the block clock.
package wdt_guard_pkg;

    // Software clear strobes gathered into one bundle
    typedef struct packed {
        logic any;   // single-mode clear
        logic one;   // dual-mode half A
        logic two;   // dual-mode half B
    } clr_strobe_t;

    // Kind of reset request raised by an overflow
    typedef enum logic [1:0] {
        OVF_NONE = 2'd0,
        OVF_FULL = 2'd1,
        OVF_WARM = 2'd2
    } ovf_kind_t;

endpackage

// File: rtl/wdt_tick_sel.sv
// Module: wdt_tick_sel
// Picks the time base of the watchdog counter and gates it.
// Assumes: lp_tick and ins_tick are one-cycle enables in the clk domain;
// the instruction clock is treated as stopped while pwr_down is high.
module wdt_tick_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_en,
    input  logic lp_clk_sel,
    input  logic lp_tick,
    input  logic ins_tick,
    input  logic pwr_down,
    output logic cnt_tick
);

    logic src_tick;

    // Choose the source and apply enable and sleep gating
    always_comb begin
        if (lp_clk_sel) begin
            src_tick = lp_tick;
        end else begin
            src_tick = ins_tick & ~pwr_down;
        end
        cnt_tick = wd_en & src_tick;
    end

    // R8
    sleep_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !lp_clk_sel) |-> !cnt_tick);

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |-> !cnt_tick);

endmodule

// File: rtl/wdt_clr_seq.sv
// Module: wdt_clr_seq
// Turns the clear strobes into one accepted software clear.
// In single mode the plain strobe is enough. In dual mode both halves must
// be seen, each kept in its own record until the pair completes.
// Assumes: halt_exec and ovf_evt are the same-cycle events of the counter.
module wdt_clr_seq
    import wdt_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dual_mode,
    input  clr_strobe_t kick,
    input  logic        halt_exec,
    input  logic        ovf_evt,
    output logic        sw_clr
);

    logic half_a_q;
    logic half_b_q;
    logic seen_a;
    logic seen_b;
    logic flush;

    // Merge stored halves with this cycle's strobes and form the clear
    always_comb begin
        seen_a = half_a_q | kick.one;
        seen_b = half_b_q | kick.two;
        if (dual_mode) begin
            sw_clr = seen_a & seen_b;
        end else begin
            sw_clr = kick.any;
        end
        flush = ~dual_mode | halt_exec | sw_clr | ovf_evt;
    end

    // Hold the received halves until the counter is restarted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_a_q <= 1'b0;
            half_b_q <= 1'b0;
        end else if (flush) begin
            half_a_q <= 1'b0;
            half_b_q <= 1'b0;
        end else begin
            half_a_q <= seen_a;
            half_b_q <= seen_b;
        end
    end

    // R6
    half_a_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_a_q) |-> ($past(kick.one) && $past(dual_mode)));

    // R6
    half_b_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_b_q) |-> ($past(kick.two) && $past(dual_mode)));

    // R6
    halves_flushed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr || halt_exec) |=> (!half_a_q && !half_b_q));

endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// The watchdog count register and its overflow detector.
// Assumes: TERM_COUNT >= 2; HALT outranks a software clear, and both
// outrank an overflow in the same cycle.
module wdt_counter #(
    parameter int unsigned TERM_COUNT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_tick,
    input  logic sw_clr,
    input  logic halt_exec,
    output logic ovf_evt
);

    localparam int unsigned CNT_W = (TERM_COUNT > 2) ? $clog2(TERM_COUNT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM_COUNT - 1);

    logic [CNT_W-1:0] count_q;

    initial begin
        if (TERM_COUNT < 2) $error("wdt_counter: TERM_COUNT must be at least 2");
    end

    // Overflow is the terminal tick that no clear pre-empts
    always_comb begin
        ovf_evt = cnt_tick & (count_q == LAST) & ~sw_clr & ~halt_exec;
    end

    // Advance, restart on clear or overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (halt_exec || sw_clr || ovf_evt) begin
            count_q <= '0;
        end else if (cnt_tick) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !sw_clr && !halt_exec && count_q != LAST)
        |=> count_q == $past(count_q) + CNT_W'(1));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !sw_clr && !halt_exec) |=> $stable(count_q));

    // R10
    clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr || halt_exec) |=> count_q == '0);

endmodule

// File: rtl/wdt_status.sv
// Module: wdt_status
// Registers the reset requests and the time-out / power-down flags.
// Assumes: ovf_evt is already suppressed by HALT and by a software clear.
module wdt_status
    import wdt_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_evt,
    input  logic pwr_down,
    input  logic sw_clr,
    input  logic halt_exec,
    output logic full_rst_req,
    output logic warm_rst_req,
    output logic to_flag,
    output logic pd_flag
);

    ovf_kind_t kind;

    // Classify the overflow by sleep state
    always_comb begin
        if (!ovf_evt) begin
            kind = OVF_NONE;
        end else if (pwr_down) begin
            kind = OVF_WARM;
        end else begin
            kind = OVF_FULL;
        end
    end

    // One-cycle request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_rst_req <= 1'b0;
            warm_rst_req <= 1'b0;
        end else begin
            full_rst_req <= (kind == OVF_FULL);
            warm_rst_req <= (kind == OVF_WARM);
        end
    end

    // Status flags; HALT outranks every other update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_flag <= 1'b0;
            pd_flag <= 1'b0;
        end else if (halt_exec) begin
            to_flag <= 1'b0;
            pd_flag <= 1'b1;
        end else begin
            if (sw_clr) pd_flag <= 1'b0;
            if (ovf_evt) to_flag <= 1'b1;
        end
    end

    // R2
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full_rst_req, warm_rst_req}));

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_rst_req || warm_rst_req) |=> (!full_rst_req && !warm_rst_req));

    // R3
    full_sets_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_rst_req |-> to_flag);

    // R4
    warm_sets_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req |-> to_flag);

    // R7
    halt_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_exec |=> (pd_flag && !to_flag && !full_rst_req && !warm_rst_req));

endmodule

// File: rtl/wdt_guard.sv
// Module: wdt_guard (top)
// Watchdog timer with selectable time base, single or dual clear
// sequencing, sleep-aware reset requests and status flags.
// Assumes: synchronous active-low reset; all inputs in the clk domain.
module wdt_guard #(
    parameter int unsigned TERM_COUNT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_en,
    input  logic dual_clr_mode,
    input  logic lp_clk_sel,
    input  logic lp_tick,
    input  logic ins_tick,
    input  logic pwr_down,
    input  logic kick,
    input  logic kick_a,
    input  logic kick_b,
    input  logic halt_exec,
    output logic full_rst_req,
    output logic warm_rst_req,
    output logic to_flag,
    output logic pd_flag
);

    import wdt_guard_pkg::*;

    clr_strobe_t kick_bus;
    logic        cnt_tick;
    logic        sw_clr;
    logic        ovf_evt;

    // Bundle the software clear strobes
    always_comb begin
        kick_bus.any = kick;
        kick_bus.one = kick_a;
        kick_bus.two = kick_b;
    end

    wdt_tick_sel u_tick_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .wd_en      (wd_en),
        .lp_clk_sel (lp_clk_sel),
        .lp_tick    (lp_tick),
        .ins_tick   (ins_tick),
        .pwr_down   (pwr_down),
        .cnt_tick   (cnt_tick)
    );

    wdt_clr_seq u_clr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dual_mode (dual_clr_mode),
        .kick      (kick_bus),
        .halt_exec (halt_exec),
        .ovf_evt   (ovf_evt),
        .sw_clr    (sw_clr)
    );

    wdt_counter #(
        .TERM_COUNT (TERM_COUNT)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_tick  (cnt_tick),
        .sw_clr    (sw_clr),
        .halt_exec (halt_exec),
        .ovf_evt   (ovf_evt)
    );

    wdt_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .ovf_evt      (ovf_evt),
        .pwr_down     (pwr_down),
        .sw_clr       (sw_clr),
        .halt_exec    (halt_exec),
        .full_rst_req (full_rst_req),
        .warm_rst_req (warm_rst_req),
        .to_flag      (to_flag),
        .pd_flag      (pd_flag)
    );

    // R5
    single_side_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_clr_mode && !kick && !halt_exec && (kick_a || kick_b) && pd_flag)
        |=> pd_flag);

    // R6
    dual_plain_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_clr_mode && kick && !kick_a && !kick_b && !halt_exec && pd_flag)
        |=> pd_flag);

endmodule

// File: tb/wdt_guard_bench.sv
// Bench for wdt_guard: directed corner cases, then fixed-seed random
// stimulus, all checked each cycle against a model built from the brief.
module wdt_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TERM       = 12;
    localparam int WDOG_LIMIT = 150000;

    logic clk = 1'b0;
    logic rstn, en, dual, lpsel, lpt, inst, pdn, k_any, k_a, k_b, hlt;
    logic full_rst_req, warm_rst_req, to_flag, pd_flag;

    int checks = 0;
    int fails  = 0;

    // bench model state
    int   m_cnt;
    logic m_ga, m_gb, m_to, m_pd, m_full, m_warm;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_guard #(.TERM_COUNT(TERM)) u_wdt_guard (
        .clk(clk), .rst_n(rstn), .wd_en(en), .dual_clr_mode(dual),
        .lp_clk_sel(lpsel), .lp_tick(lpt), .ins_tick(inst), .pwr_down(pdn),
        .kick(k_any), .kick_a(k_a), .kick_b(k_b), .halt_exec(hlt),
        .full_rst_req(full_rst_req), .warm_rst_req(warm_rst_req),
        .to_flag(to_flag), .pd_flag(pd_flag)
    );

    // selected, gated tick (R8, R9)
    function automatic logic f_tick(logic e, logic sel, logic lp, logic ins, logic pd);
        return e & (sel ? lp : (ins & ~pd));
    endfunction

    // accepted software clear (R5, R6)
    function automatic logic f_done(logic d, logic ga, logic gb,
                                    logic ka, logic kb, logic kany);
        return d ? ((ga | ka) & (gb | kb)) : kany;
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // advance model and design one cycle, then compare all outputs
    task automatic step(input string tag);
        logic t, d, o;
        if (!rstn) begin
            m_cnt = 0; m_ga = 0; m_gb = 0; m_to = 0; m_pd = 0; m_full = 0; m_warm = 0;
        end else begin
            t = f_tick(en, lpsel, lpt, inst, pdn);
            d = f_done(dual, m_ga, m_gb, k_a, k_b, k_any);
            o = t && (m_cnt == TERM-1) && !hlt && !d;
            m_full = o & ~pdn;
            m_warm = o & pdn;
            if (hlt) begin
                m_cnt = 0; m_pd = 1; m_to = 0;
            end else if (d) begin
                m_cnt = 0; m_pd = 0;
            end else if (o) begin
                m_cnt = 0; m_to = 1;
            end else if (t) begin
                m_cnt = m_cnt + 1;
            end
            if (!dual || hlt || d || o) begin
                m_ga = 0; m_gb = 0;
            end else begin
                m_ga = m_ga | k_a; m_gb = m_gb | k_b;
            end
        end
        @(posedge clk);
        #1;
        chk(tag, "full_rst_req", full_rst_req, m_full);
        chk(tag, "warm_rst_req", warm_rst_req, m_warm);
        chk(tag, "to_flag", to_flag, m_to);
        chk(tag, "pd_flag", pd_flag, m_pd);
        lpt = 0; inst = 0; k_any = 0; k_a = 0; k_b = 0; hlt = 0; rstn = 1;
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            lpt = 1; inst = 1;
            step(tag);
        end
    endtask

    task automatic to_last(input string tag);
        while (m_cnt != TERM-1) begin
            lpt = 1; inst = 1;
            step(tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WDOG_LIMIT);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c1a));
        rstn = 0; en = 1; dual = 0; lpsel = 1; lpt = 0; inst = 0; pdn = 0;
        k_any = 0; k_a = 0; k_b = 0; hlt = 0;
        m_cnt = 0; m_ga = 0; m_gb = 0; m_to = 0; m_pd = 0; m_full = 0; m_warm = 0;
        @(negedge clk);
        // R1 reset state, with strobes active during reset
        rstn = 0; hlt = 1; lpt = 1; step("R1");
        rstn = 0; step("R1");

        // R2 / R3: awake overflow on the TERM-th tick, single-cycle pulse
        ticks(TERM - 1, "R2");
        chk("R2", "no early request", full_rst_req, 1'b0);
        ticks(1, "R3");
        chk("R3", "full pulse", full_rst_req, 1'b1);
        step("R2");
        chk("R2", "pulse ends", full_rst_req, 1'b0);

        // R7: HALT clears TO, sets PDF; HALT on terminal tick wins
        to_last("R7");
        hlt = 1; lpt = 1; step("R7");
        chk("R7", "pd after halt", pd_flag, 1'b1);
        chk("R7", "no request", full_rst_req | warm_rst_req, 1'b0);

        // R4: asleep on low-power base gives warm request
        pdn = 1;
        ticks(TERM, "R4");
        chk("R4", "warm pulse", warm_rst_req, 1'b1);
        chk("R4", "to set", to_flag, 1'b1);

        // R8: instruction clock stops during sleep
        lpsel = 0;
        ticks(3 * TERM, "R8");
        pdn = 0;
        ticks(TERM, "R8");

        // R5: single mode, halves ignored, kick clears PDF
        hlt = 1; step("R7");
        k_a = 1; k_b = 1; step("R5");
        chk("R5", "halves ignored", pd_flag, 1'b1);
        to_last("R10");
        k_any = 1; inst = 1; step("R10");
        chk("R10", "clear beats overflow", full_rst_req, 1'b0);
        chk("R5", "pd cleared", pd_flag, 1'b0);

        // R6: dual mode, B then A, kick ignored, simultaneous pair
        dual = 1; hlt = 1; step("R7");
        k_any = 1; step("R6");
        chk("R6", "plain kick ignored", pd_flag, 1'b1);
        k_b = 1; ticks(2, "R6");
        to_last("R6");
        k_a = 1; inst = 1; step("R6");
        chk("R6", "pair beats overflow", full_rst_req, 1'b0);
        hlt = 1; step("R7");
        k_a = 1; k_b = 1; step("R6");
        chk("R6", "same-cycle pair", pd_flag, 1'b0);

        // R9: disabled watchdog never overflows
        en = 0;
        ticks(3 * TERM, "R9");
        en = 1;

        // random phase
        for (int cyc = 0; cyc < 6000; cyc++) begin
            if (cyc % 250 == 0) begin
                dual  = $urandom_range(0, 1);
                lpsel = $urandom_range(0, 1);
            end
            if ($urandom_range(0, 40) == 0) pdn = ~pdn;
            en    = ($urandom_range(0, 9) != 0);
            lpt   = $urandom_range(0, 1);
            inst  = $urandom_range(0, 1);
            k_any = ($urandom_range(0, 25) == 0);
            k_a   = ($urandom_range(0, 20) == 0);
            k_b   = ($urandom_range(0, 20) == 0);
            hlt   = ($urandom_range(0, 90) == 0);
            rstn  = ($urandom_range(0, 999) != 0);
            step("R2");
        end

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule